// File: doc/BRIEF.md
# Slowdown-Proportional Priority Epoch Arbiter

This block picks requests out of a shared memory request buffer on behalf of several applications. Time is cut into fixed-length epochs. During each epoch one application is the owner and holds absolute priority: whenever it has anything waiting, its request is the one sent on, however long other applications' requests have been waiting. Epochs are grouped into quanta. Within a quantum, each application owns a number of epochs that grows with its most recent slowdown figure. That figure comes in on a port, for example from a stage upstream that also sizes cache partitions, so cache and bandwidth control can be driven by the same numbers.

The slowdown figures are sampled only at a quantum boundary. The epoch counts come from a floor division, and the epochs it leaves over are handed out one each. Owners appear in ascending application order, each for a run of consecutive epochs. The chosen request goes into a one-entry output register towards a ready/valid sink. The block also shows the current owner and whether the owner has a request waiting.

Top module: `slowdown_epoch_arbiter`

## Requirements
- R1: When a request is moved to the output register and the epoch owner has any request in the buffer, the moved request is the owner's, regardless of arrival order.
- R2: Two owner requests buffered with a request of another application between them leave the buffer in consecutive service slots, within one epoch.
- R3: Among the owner's requests, and among requests of non-owners when the owner has none, the oldest accepted request is taken first.
- R4: With total slowdown S > 0 and EPOCHS_PER_Q = E, application i owns at least floor(E * s_i / S) epochs of the quantum. An application with slowdown 0 gets no epoch unless the leftover rule gives it one.
- R5: The leftover epochs (E minus the sum of the floors) go one each to consecutive application indices, wrapping, starting from the application with the largest slowdown. On a tie, the lowest index counts as largest.
- R6: When every slowdown input is 0, including the first quantum after reset, the quantum is divided as if every slowdown were 1.
- R7: The slowdown inputs are sampled only on the clock edge that ends a quantum. A change at any other time has no effect on `owner` until that edge.
- R8: `owner` changes only every EPOCH_LEN cycles. Within a quantum, application 0 owns the first run of epochs, application 1 owns the next run, and so on, in ascending index order.
- R9: While `gnt_valid` is 1 and `gnt_ready` is 0, `gnt_valid`, `gnt_app` and `gnt_tag` hold their values on the next cycle.
- R10: `hp_busy` is 1 exactly when the buffer holds at least one request of the current owner. The request in the output register does not count.
- R11: The buffer holds QDEPTH requests. `req_ready` is 0 while it is full, and a request offered then is dropped.
- R12: After synchronous reset the block has an empty buffer, `gnt_valid` 0, `req_ready` 1, `hp_busy` 0, epoch 0 and `owner` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slowdown | input | NUM_APPS*SD_W | Unsigned slowdown per application, application i in bits [i*SD_W +: SD_W] |
| req_valid | input | 1 | Request offered |
| req_app | input | APP_W | Application issuing the request |
| req_tag | input | TAG_W | Request payload carried to the grant |
| req_ready | output | 1 | Buffer has room; request accepted when valid and ready |
| gnt_valid | output | 1 | Output register holds a selected request |
| gnt_app | output | APP_W | Application of the selected request |
| gnt_tag | output | TAG_W | Payload of the selected request |
| gnt_ready | input | 1 | Sink takes the request when valid and ready |
| owner | output | APP_W | Application owning the current epoch |
| hp_busy | output | 1 | Owner has a request waiting in the buffer |

## Verification
Several properties are checked on every cycle: that the owner changes only on epoch boundaries counted independently of the design, that a stalled grant is held, that a buffer move made while the owner has work yields an owner request, that the buffer level does not move under backpressure with nothing taken, and that reset returns the outputs to idle. The epoch counts per application, the leftover rule, the all-zero case and the deferral of slowdown changes to the quantum edge depend on arithmetic over a whole quantum. Only the bench's reference schedule, compared each cycle, can show them. The same applies to the exact service order in the back-to-back and oldest-first scenarios.

// File: rtl/sea_pkg.sv
package sea_pkg;
  // Distance from start to idx walking upward through n slots with wrap.
  function automatic int rr_dist(input int idx, input int start, input int n);
    return (idx >= start) ? (idx - start) : (idx + n - start);
  endfunction
endpackage

// File: rtl/sea_share_alloc.sv
module sea_share_alloc #(
  parameter int NUM_APPS = 4,
  parameter int SD_W = 8,
  parameter int EPQ = 8,
  localparam int EW = $clog2(EPQ + 1)
) (
  input  logic [NUM_APPS*SD_W-1:0] sd_vec,
  output logic [NUM_APPS*EW-1:0]   cnt_vec
);
  localparam int SW = SD_W + $clog2(NUM_APPS) + 1;
  localparam int PW = SD_W + EW;
  localparam int DW = (PW > SW) ? PW : SW;

  logic [SD_W-1:0] eff   [NUM_APPS];
  logic [EW-1:0]   share [NUM_APPS];
  logic [SW-1:0]   tot_sd;
  logic [SW-1:0]   div_sd;
  logic [EW-1:0]   given;
  logic [EW-1:0]   spare;
  int              top_i;

  always_comb begin
    tot_sd = '0;
    for (int i = 0; i < NUM_APPS; i++)
      tot_sd = tot_sd + SW'(sd_vec[i*SD_W +: SD_W]);
    // all-zero inputs behave as equal unit weights
    for (int i = 0; i < NUM_APPS; i++)
      eff[i] = (tot_sd == '0) ? SD_W'(1) : sd_vec[i*SD_W +: SD_W];
    div_sd = (tot_sd == '0) ? SW'(NUM_APPS) : tot_sd;
    given = '0;
    for (int i = 0; i < NUM_APPS; i++) begin
      share[i] = EW'((DW'(EPQ) * DW'(eff[i])) / DW'(div_sd));
      given    = given + share[i];
    end
    spare = EW'(EPQ) - given;
    top_i = 0;
    for (int i = 1; i < NUM_APPS; i++)
      if (eff[i] > eff[top_i]) top_i = i;
    // spare < NUM_APPS, so each index gets at most one extra epoch
    for (int i = 0; i < NUM_APPS; i++)
      cnt_vec[i*EW +: EW] = share[i] +
        EW'(sea_pkg::rr_dist(i, top_i, NUM_APPS) < int'(spare));
  end
endmodule

// File: rtl/sea_epoch_sched.sv
module sea_epoch_sched #(
  parameter int NUM_APPS = 4,
  parameter int SD_W = 8,
  parameter int EPOCH_LEN = 16,
  parameter int EPQ = 8,
  localparam int APP_W = $clog2(NUM_APPS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_APPS*SD_W-1:0] slowdown,
  output logic [APP_W-1:0]         owner
);
  localparam int CW = $clog2(EPOCH_LEN);
  localparam int PW = $clog2(EPQ);
  localparam int EW = $clog2(EPQ + 1);
  localparam int AW = EW + 1;

  logic [CW-1:0]            cyc_q;
  logic [PW-1:0]            ep_q;
  logic [NUM_APPS*EW-1:0]   cnt_q;
  logic [NUM_APPS*EW-1:0]   cnt_new;
  logic [NUM_APPS*SD_W-1:0] sd_in;
  logic                     epoch_end;
  logic                     quant_end;
  logic [AW-1:0]            acc;

  // under reset the allocator sees zeros and yields the equal split
  assign sd_in = rst ? '0 : slowdown;

  sea_share_alloc #(.NUM_APPS(NUM_APPS), .SD_W(SD_W), .EPQ(EPQ)) u_alloc (
    .sd_vec (sd_in),
    .cnt_vec(cnt_new)
  );

  assign epoch_end = (cyc_q == CW'(EPOCH_LEN - 1));
  assign quant_end = epoch_end && (ep_q == PW'(EPQ - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q <= '0;
      ep_q  <= '0;
      cnt_q <= cnt_new;
    end else begin
      cyc_q <= epoch_end ? '0 : cyc_q + CW'(1);
      if (epoch_end) ep_q <= quant_end ? '0 : ep_q + PW'(1);
      if (quant_end) cnt_q <= cnt_new;
    end
  end

  // owner = number of applications whose run of epochs ends at or before ep_q
  always_comb begin
    acc   = '0;
    owner = '0;
    for (int i = 0; i < NUM_APPS; i++) begin
      acc = acc + AW'(cnt_q[i*EW +: EW]);
      if (AW'(ep_q) >= acc) owner = owner + APP_W'(1);
    end
  end
endmodule

// File: rtl/sea_req_queue.sv
module sea_req_queue #(
  parameter int NUM_APPS = 4,
  parameter int QDEPTH = 8,
  parameter int TAG_W = 8,
  localparam int APP_W = $clog2(NUM_APPS),
  localparam int QW = $clog2(QDEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [APP_W-1:0] push_app,
  input  logic [TAG_W-1:0] push_tag,
  input  logic             pop,
  input  logic [APP_W-1:0] owner,
  output logic [QW-1:0]    q_cnt,
  output logic             sel_valid,
  output logic [APP_W-1:0] sel_app,
  output logic [TAG_W-1:0] sel_tag,
  output logic             owner_pend
);
  localparam int IXW = $clog2(QDEPTH);

  // slot 0 is always the oldest entry; entries stay in arrival order
  logic [APP_W-1:0] app_q [QDEPTH];
  logic [TAG_W-1:0] tag_q [QDEPTH];
  logic [APP_W-1:0] sh_app [QDEPTH];
  logic [TAG_W-1:0] sh_tag [QDEPTH];
  logic [QW-1:0]    cnt_q;
  logic [IXW-1:0]   sel_idx;
  logic [QW-1:0]    wr_idx;

  always_comb begin
    owner_pend = 1'b0;
    sel_idx    = '0;
    for (int j = QDEPTH - 1; j >= 0; j--) begin
      if (QW'(j) < cnt_q && app_q[j] == owner) begin
        owner_pend = 1'b1;
        sel_idx    = IXW'(j);
      end
    end
  end

  assign sel_valid = (cnt_q != '0);
  assign sel_app   = app_q[sel_idx];
  assign sel_tag   = tag_q[sel_idx];
  assign q_cnt     = cnt_q;
  assign wr_idx    = cnt_q - QW'(pop);

  always_comb begin
    for (int j = 0; j < QDEPTH; j++) begin
      sh_app[j] = app_q[(j < QDEPTH - 1) ? j + 1 : j];
      sh_tag[j] = tag_q[(j < QDEPTH - 1) ? j + 1 : j];
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < QDEPTH; j++) begin
      if (push && wr_idx == QW'(j)) begin
        app_q[j] <= push_app;
        tag_q[j] <= push_tag;
      end else if (pop && IXW'(j) >= sel_idx) begin
        app_q[j] <= sh_app[j];
        tag_q[j] <= sh_tag[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + QW'(push) - QW'(pop);
  end
endmodule

// File: rtl/slowdown_epoch_arbiter.sv
module slowdown_epoch_arbiter #(
  parameter int NUM_APPS = 4,
  parameter int SD_W = 8,
  parameter int EPOCH_LEN = 16,
  parameter int EPOCHS_PER_Q = 8,
  parameter int QDEPTH = 8,
  parameter int TAG_W = 8,
  localparam int APP_W = $clog2(NUM_APPS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_APPS*SD_W-1:0] slowdown,
  input  logic                     req_valid,
  input  logic [APP_W-1:0]         req_app,
  input  logic [TAG_W-1:0]         req_tag,
  output logic                     req_ready,
  output logic                     gnt_valid,
  output logic [APP_W-1:0]         gnt_app,
  output logic [TAG_W-1:0]         gnt_tag,
  input  logic                     gnt_ready,
  output logic [APP_W-1:0]         owner,
  output logic                     hp_busy
);
  localparam int QW = $clog2(QDEPTH + 1);

  logic [QW-1:0]    q_cnt;
  logic             sel_valid;
  logic [APP_W-1:0] sel_app;
  logic [TAG_W-1:0] sel_tag;
  logic             push;
  logic             take;

  sea_epoch_sched #(
    .NUM_APPS(NUM_APPS), .SD_W(SD_W), .EPOCH_LEN(EPOCH_LEN), .EPQ(EPOCHS_PER_Q)
  ) u_sched (
    .clk     (clk),
    .rst     (rst),
    .slowdown(slowdown),
    .owner   (owner)
  );

  assign req_ready = (q_cnt != QW'(QDEPTH));
  assign push      = req_valid && req_ready;
  assign take      = sel_valid && (!gnt_valid || gnt_ready);

  sea_req_queue #(.NUM_APPS(NUM_APPS), .QDEPTH(QDEPTH), .TAG_W(TAG_W)) u_queue (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_app  (req_app),
    .push_tag  (req_tag),
    .pop       (take),
    .owner     (owner),
    .q_cnt     (q_cnt),
    .sel_valid (sel_valid),
    .sel_app   (sel_app),
    .sel_tag   (sel_tag),
    .owner_pend(hp_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_valid <= 1'b0;
    end else if (take) begin
      gnt_valid <= 1'b1;
    end else if (gnt_ready) begin
      gnt_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      gnt_app <= sel_app;
      gnt_tag <= sel_tag;
    end
  end
endmodule

// File: rtl/sea_checker.sv
module sea_checker #(
  parameter int NUM_APPS = 4,
  parameter int EPOCH_LEN = 16,
  parameter int QDEPTH = 8,
  parameter int TAG_W = 8,
  localparam int APP_W = $clog2(NUM_APPS),
  localparam int QW = $clog2(QDEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [APP_W-1:0] owner,
  input logic             gnt_valid,
  input logic             gnt_ready,
  input logic [APP_W-1:0] gnt_app,
  input logic [TAG_W-1:0] gnt_tag,
  input logic             take,
  input logic             hp_busy,
  input logic             req_ready,
  input logic [QW-1:0]    q_cnt
);
  localparam int CW = $clog2(EPOCH_LEN);
  logic [CW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= (phase_q == CW'(EPOCH_LEN - 1)) ? '0 : phase_q + CW'(1);
  end

  // R8
  owner_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (owner != $past(owner)) |-> (phase_q == '0));

  // R9
  gnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && !gnt_ready) |=> (gnt_valid && $stable(gnt_app) && $stable(gnt_tag)));

  // R1
  owner_first_chk: assert property (@(posedge clk) disable iff (rst)
    (take && hp_busy) |=> (gnt_app == $past(owner)));

  // R11
  full_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !take) |=> $stable(q_cnt));

  // R12
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!gnt_valid && owner == '0 && !hp_busy));
endmodule

bind slowdown_epoch_arbiter sea_checker #(
  .NUM_APPS(NUM_APPS), .EPOCH_LEN(EPOCH_LEN), .QDEPTH(QDEPTH), .TAG_W(TAG_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .owner    (owner),
  .gnt_valid(gnt_valid),
  .gnt_ready(gnt_ready),
  .gnt_app  (gnt_app),
  .gnt_tag  (gnt_tag),
  .take     (take),
  .hp_busy  (hp_busy),
  .req_ready(req_ready),
  .q_cnt    (q_cnt)
);

// File: tb/sim_slowdown_epoch_arbiter.sv
module sim_slowdown_epoch_arbiter;
  localparam int N = 4, SDW = 8, L = 16, E = 8, D = 8, TW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int               sd [N];
  logic [N*SDW-1:0] slowdown;
  logic             req_valid = 1'b0;
  logic [1:0]       req_app = '0;
  logic [TW-1:0]    req_tag = '0;
  logic             req_ready;
  logic             gnt_valid;
  logic [1:0]       gnt_app;
  logic [TW-1:0]    gnt_tag;
  logic             gnt_ready = 1'b0;
  logic [1:0]       owner;
  logic             hp_busy;

  always_comb
    for (int i = 0; i < N; i++) slowdown[i*SDW +: SDW] = SDW'(sd[i]);

  slowdown_epoch_arbiter #(
    .NUM_APPS(N), .SD_W(SDW), .EPOCH_LEN(L), .EPOCHS_PER_Q(E), .QDEPTH(D), .TAG_W(TW)
  ) u0 (
    .clk(clk), .rst(rst), .slowdown(slowdown),
    .req_valid(req_valid), .req_app(req_app), .req_tag(req_tag), .req_ready(req_ready),
    .gnt_valid(gnt_valid), .gnt_app(gnt_app), .gnt_tag(gnt_tag), .gnt_ready(gnt_ready),
    .owner(owner), .hp_busy(hp_busy)
  );

  int checks = 0, fails = 0;
  string own_tag = "R6";
  string cur_tag = "R3";
  int tagc = 0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at k", rq, what, act, exp);
    end
  endtask

  // reference epoch counts from R4, R5, R6
  int exp_cnt [N];
  function automatic void calc_counts();
    int tot, se, given, spare, mx;
    int eff [N];
    tot = 0;
    for (int i = 0; i < N; i++) tot += sd[i];
    se = (tot == 0) ? N : tot;
    for (int i = 0; i < N; i++) eff[i] = (tot == 0) ? 1 : sd[i];
    given = 0;
    for (int i = 0; i < N; i++) begin
      exp_cnt[i] = (E * eff[i]) / se;
      given += exp_cnt[i];
    end
    spare = E - given;
    mx = 0;
    for (int i = 1; i < N; i++) if (eff[i] > eff[mx]) mx = i;
    for (int d = 0; d < spare; d++) exp_cnt[(mx + d) % N]++;
  endfunction

  // R8: epochs laid out in ascending application order
  function automatic int lookup(input int ep);
    int acc;
    acc = 0;
    for (int i = 0; i < N; i++) begin
      acc += exp_cnt[i];
      if (ep < acc) return i;
    end
    return N - 1;
  endfunction

  // reference buffer and output register
  int k = 0;
  int mq_app[$];
  int mq_tag[$];
  bit mv = 0;
  int ma = 0, mt = 0, pown = 0, own = 0, idx = 0, n = 0;
  bit take, room, pend;

  always @(posedge clk) begin
    #1;
    if (rst) begin
      k = 0; mv = 0; pown = 0;
      mq_app.delete(); mq_tag.delete();
      for (int i = 0; i < N; i++) sd[i] = sd[i];
      begin
        int keep [N];
        for (int i = 0; i < N; i++) begin keep[i] = sd[i]; sd[i] = 0; end
        calc_counts();
        for (int i = 0; i < N; i++) sd[i] = keep[i];
      end
      chk(gnt_valid == 1'b0, "R12", "gnt_valid", int'(gnt_valid), 0);
      chk(req_ready == 1'b1, "R12", "req_ready", int'(req_ready), 1);
      chk(owner == 2'd0, "R12", "owner", int'(owner), 0);
      chk(hp_busy == 1'b0, "R12", "hp_busy", int'(hp_busy), 0);
    end else begin
      n = mq_app.size();
      room = (n < D);
      take = (n > 0) && (!mv || gnt_ready);
      if (take) begin
        idx = 0;
        for (int i = n - 1; i >= 0; i--) if (mq_app[i] == pown) idx = i;
        ma = mq_app[idx]; mt = mq_tag[idx];
        mq_app.delete(idx); mq_tag.delete(idx);
        mv = 1;
      end else if (gnt_ready) begin
        mv = 0;
      end
      if (req_valid && room) begin
        mq_app.push_back(int'(req_app));
        mq_tag.push_back(int'(req_tag));
      end
      k++;
      if (k % (L * E) == 0) calc_counts();
      own = lookup((k / L) % E);
      pend = 0;
      foreach (mq_app[i]) if (mq_app[i] == own) pend = 1;
      chk(int'(owner) == own, own_tag, "owner", int'(owner), own);
      chk(gnt_valid == mv, cur_tag, "gnt_valid", int'(gnt_valid), int'(mv));
      if (mv) begin
        chk(int'(gnt_app) == ma, cur_tag, "gnt_app", int'(gnt_app), ma);
        chk(int'(gnt_tag) == mt, cur_tag, "gnt_tag", int'(gnt_tag), mt);
      end
      chk(hp_busy == pend, "R10", "hp_busy", int'(hp_busy), int'(pend));
      chk(req_ready == (mq_app.size() < D), "R11", "req_ready", int'(req_ready),
          int'(mq_app.size() < D));
      pown = own;
    end
  end

  task automatic drive(input bit v, input int app);
    @(negedge clk);
    req_valid = v;
    req_app   = 2'(app);
    req_tag   = TW'(tagc);
    tagc++;
  endtask

  task automatic wait_k(input int t);
    while (k < t) @(negedge clk);
  endtask

  task automatic align_epoch();
    @(negedge clk);
    while (k % L != 1) @(negedge clk);
  endtask

  task automatic drain(input int cyc);
    gnt_ready = 1'b1;
    repeat (cyc) drive(0, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", k, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd5011));
    for (int i = 0; i < N; i++) sd[i] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R2: owner, other, owner queued back to back under stall
    align_epoch();
    cur_tag = "R2";
    gnt_ready = 1'b0;
    drive(1, pown); drive(1, (pown + 1) % N); drive(1, pown); drive(0, 0);
    drain(5);

    // R1: non-owner requests first, owner request last
    align_epoch();
    cur_tag = "R1";
    gnt_ready = 1'b0;
    drive(1, (pown + 1) % N); drive(1, (pown + 2) % N); drive(1, (pown + 3) % N);
    drive(1, pown); drive(0, 0);
    drain(6);

    // R3: only non-owners queued, served oldest first
    align_epoch();
    cur_tag = "R3";
    gnt_ready = 1'b0;
    drive(1, (pown + 2) % N); drive(1, (pown + 1) % N); drive(1, (pown + 3) % N);
    drive(1, (pown + 1) % N); drive(0, 0);
    drain(6);

    // R11: overfill the buffer with the sink stalled
    cur_tag = "R9";
    gnt_ready = 1'b0;
    for (int i = 0; i < 12; i++) drive(1, i % N);
    drive(0, 0);
    drain(12);

    // R7: change mid-quantum, must not move the owner until k=128
    wait_k(105);
    own_tag = "R7";
    sd[0] = 3; sd[1] = 1; sd[2] = 1; sd[3] = 1;
    wait_k(128);
    own_tag = "R5";
    cur_tag = "R1";
    // R5 quantum: counts 5,1,1,1 with leftover to the largest
    while (k < 200) begin
      gnt_ready = ($urandom % 4) != 0;
      drive(($urandom % 3) != 0, $urandom % N);
    end
    sd[0] = 200; sd[1] = 0; sd[2] = 0; sd[3] = 0;
    wait_k(256);
    own_tag = "R4";
    while (k < 320) begin
      gnt_ready = ($urandom % 4) != 0;
      drive(($urandom % 3) != 0, $urandom % N);
    end
    sd[0] = 1; sd[1] = 2; sd[2] = 0; sd[3] = 2;
    wait_k(384);
    own_tag = "R5";
    while (k < 450) begin
      gnt_ready = ($urandom % 2) != 0;
      drive(($urandom % 3) != 0, $urandom % N);
    end
    for (int i = 0; i < N; i++) sd[i] = 0;
    wait_k(512);
    own_tag = "R6";
    while (k < 600) begin
      gnt_ready = ($urandom % 4) != 0;
      drive(($urandom % 3) != 0, $urandom % N);
    end

    // R8/R9: random slowdowns and traffic
    wait_k(640);
    own_tag = "R8";
    cur_tag = "R9";
    while (k < 640 + 10 * L * E) begin
      if (k % (L * E) == 60)
        for (int i = 0; i < N; i++) sd[i] = (($urandom % 3) == 0) ? 0 : int'($urandom % 256);
      gnt_ready = ($urandom % 3) != 0;
      drive(($urandom % 4) != 0, $urandom % N);
    end
    drain(12);
    finish_run();
  end
endmodule